// File: doc/BRIEF.md
# Signed-Digit Partial-Product Summing Tree

This block is the summing half of a parallel multiplier. It takes eight partial products, already shifted into place by a recoding stage. Each partial product arrives in redundant signed-digit form: a positive bit vector and a negative bit vector, 48 digit positions wide. The block folds the eight operands to one with a binary tree of carry-free adders. Every adder turns two signed-digit operands into one, so the tree has depth three and 4 + 2 + 1 adders. The redundant sum is resolved to ordinary two's complement exactly once, in a parallel-prefix carry-propagate converter at the output.

A digit adder works in two steps. The first step splits the digit sum at each position into an interim digit and a transfer digit. It looks at the neighbouring lower position, so the later step cannot overflow. The second step adds the transfer coming up from below and creates no new carry. The delay of an adder therefore does not grow with the width. With recoded 24x24-bit operands the 48-bit result is the signed product.

A parameter can place a register between the tree and the converter. The default latency is two cycles and a new operand set can be accepted every cycle.

Top module: `sd_product_tree`

## Requirements
- R1: One accepted operand set leads to one result on `product_o`. That result equals the sum over k of (P_k − N_k), taken modulo 2^48, where P_k is `pp_pos_i[48k+47:48k]` and N_k is `pp_neg_i[48k+47:48k]`. When the inputs are radix-8 recoded partial products of two signed 24-bit operands, the result is their signed product.
- R2: Each digit position holds one positive bit and one negative bit. The pairs (pos=1, neg=0), (0,1), (0,0) and (1,1) stand for +1, −1, 0 and 0. Pairs with both bits set are accepted and count as zero.
- R3: Only the value P_k − N_k counts. Two encodings of the same value give the same product. One example is a triple multiple given as four times on the positive side and once on the negative side.
- R4: Sums beyond the 48-bit range wrap modulo 2^48. There is no saturation and no overflow indication.
- R5: `out_valid_o` is high for exactly one cycle, 1 + TREE_REG clock cycles after `in_valid_i` was sampled high (2 with the default). Operand sets presented back to back produce results back to back, in order.
- R6: While `out_valid_o` is low, `product_o` keeps its previous value. Inputs presented with `in_valid_i` low do not change it.
- R7: While `rst_n` is low, `out_valid_o` is 0 and `product_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand set on the partial-product buses is valid this cycle |
| pp_pos_i | input | 384 | Positive digit bits of the eight partial products, operand k in bits 48k+47:48k |
| pp_neg_i | input | 384 | Negative digit bits of the eight partial products, same layout |
| out_valid_o | output | 1 | `product_o` carries a new result this cycle |
| product_o | output | 48 | Two's-complement result, modulo 2^48 |

## Verification
The embedded properties check three things on every accepted operand set: the tree root's value equals the sum of the leaf values, the root digits are in canonical form, and each registered result equals the converted root value from the cycle before. They also check at all times that the valid signal lags the input by the fixed latency and that the output holds between results. A real multiplication, however, is only shown by the bench's scenarios. These build radix-8 recoded operands, including the extreme values of both signs and alternative encodings of the same multiple, and compare the result with a signed multiply. The wrap-around behaviour and the treatment of both-set digit pairs are likewise shown only by directed and random bench scenarios.

// File: rtl/sd_pkg.sv
package sd_pkg;

   // one redundant binary digit: value is pos - neg
   typedef struct packed {
      logic pos;
      logic neg;
   } sdig_t;

   function automatic logic signed [2:0] sdig_val(input sdig_t d);
      if (d.pos && !d.neg)      return 3'sd1;
      else if (d.neg && !d.pos) return -3'sd1;
      else                      return 3'sd0;
   endfunction

   // canonical encoding, never both bits set
   function automatic sdig_t sdig_enc(input logic signed [2:0] v);
      sdig_t d;
      d.pos = (v > 3'sd0);
      d.neg = (v < 3'sd0);
      return d;
   endfunction

endpackage

// File: rtl/sd_digit_cell.sv
module sd_digit_cell
   import sd_pkg::*;
(
   input  sdig_t x_i,
   input  sdig_t y_i,
   input  logic  low_nonneg_i,
   input  sdig_t xfer_i,
   output sdig_t xfer_o,
   output sdig_t sum_o
);

   logic signed [2:0] dsum;
   logic signed [2:0] interim;
   logic signed [2:0] xfer;
   logic signed [2:0] final_d;

   // step one: split into transfer and interim digit using lower position
   // step two: absorb incoming transfer, no new carry possible
   always_comb begin
      dsum    = sdig_val(x_i) + sdig_val(y_i);
      xfer    = 3'sd0;
      interim = 3'sd0;
      if (dsum == 3'sd2) begin
         xfer = 3'sd1;
      end else if (dsum == -3'sd2) begin
         xfer = -3'sd1;
      end else if (dsum == 3'sd1) begin
         if (low_nonneg_i) begin
            xfer    = 3'sd1;
            interim = -3'sd1;
         end else begin
            interim = 3'sd1;
         end
      end else if (dsum == -3'sd1) begin
         if (low_nonneg_i) begin
            interim = -3'sd1;
         end else begin
            xfer    = -3'sd1;
            interim = 3'sd1;
         end
      end
      final_d = interim + sdig_val(xfer_i);
   end

   assign xfer_o = sdig_enc(xfer);
   assign sum_o  = sdig_enc(final_d);

endmodule

// File: rtl/sd_vec_add.sv
module sd_vec_add
   import sd_pkg::*;
#(
   parameter int WIDTH = 48
) (
   input  logic [WIDTH-1:0] a_pos_i,
   input  logic [WIDTH-1:0] a_neg_i,
   input  logic [WIDTH-1:0] b_pos_i,
   input  logic [WIDTH-1:0] b_neg_i,
   output logic [WIDTH-1:0] s_pos_o,
   output logic [WIDTH-1:0] s_neg_o
);

   sdig_t xfer [WIDTH];
   logic  unused_top_xfer;

   for (genvar i = 0; i < WIDTH; i++) begin : g_dig
      sdig_t tin;
      sdig_t res;
      logic  low_ok;
      if (i == 0) begin : g_lsb
         assign tin    = '0;
         assign low_ok = 1'b1;
      end else begin : g_upper
         assign tin    = xfer[i-1];
         assign low_ok = ~(a_neg_i[i-1] & ~a_pos_i[i-1]) &
                         ~(b_neg_i[i-1] & ~b_pos_i[i-1]);
      end
      sd_digit_cell u_cell (
         .x_i          ({a_pos_i[i], a_neg_i[i]}),
         .y_i          ({b_pos_i[i], b_neg_i[i]}),
         .low_nonneg_i (low_ok),
         .xfer_i       (tin),
         .xfer_o       (xfer[i]),
         .sum_o        (res)
      );
      assign s_pos_o[i] = res.pos;
      assign s_neg_o[i] = res.neg;
   end

   // transfer out of the top digit has weight 2^WIDTH: dropped (modulo result)
   assign unused_top_xfer = ^xfer[WIDTH-1];

endmodule

// File: rtl/sd_tree.sv
module sd_tree #(
   parameter int WIDTH   = 48,
   parameter int NUM_OPS = 8
) (
   input  logic [NUM_OPS*WIDTH-1:0] leaf_pos_i,
   input  logic [NUM_OPS*WIDTH-1:0] leaf_neg_i,
   output logic [WIDTH-1:0]         root_pos_o,
   output logic [WIDTH-1:0]         root_neg_o
);

   localparam int NODES = 2 * NUM_OPS - 1;
   localparam int FIRST_LEAF = NUM_OPS - 1;

   // heap layout: node i has children 2i+1 and 2i+2, leaves at the tail
   logic [WIDTH-1:0] node_p [NODES];
   logic [WIDTH-1:0] node_n [NODES];

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_leaf
      assign node_p[FIRST_LEAF+k] = leaf_pos_i[k*WIDTH +: WIDTH];
      assign node_n[FIRST_LEAF+k] = leaf_neg_i[k*WIDTH +: WIDTH];
   end

   for (genvar i = 0; i < FIRST_LEAF; i++) begin : g_node
      sd_vec_add #(.WIDTH(WIDTH)) u_add (
         .a_pos_i (node_p[2*i+1]),
         .a_neg_i (node_n[2*i+1]),
         .b_pos_i (node_p[2*i+2]),
         .b_neg_i (node_n[2*i+2]),
         .s_pos_o (node_p[i]),
         .s_neg_o (node_n[i])
      );
   end

   assign root_pos_o = node_p[0];
   assign root_neg_o = node_n[0];

endmodule

// File: rtl/sd_to_bin.sv
module sd_to_bin #(
   parameter int WIDTH = 48
) (
   input  logic [WIDTH-1:0] pos_i,
   input  logic [WIDTH-1:0] neg_i,
   output logic [WIDTH-1:0] bin_o
);

   localparam int STAGES = $clog2(WIDTH);

   // pos - neg = pos + ~neg + 1, carry-in folded into bit 0
   logic [WIDTH-1:0] opb;
   logic [WIDTH-1:0] half;
   logic [WIDTH-1:0] gk [STAGES+1];
   logic [WIDTH-1:0] pk [STAGES+1];
   logic             unused_prefix;

   assign opb   = ~neg_i;
   assign half  = pos_i ^ opb;
   assign gk[0] = {pos_i[WIDTH-1:1] & opb[WIDTH-1:1], pos_i[0] | opb[0]};
   assign pk[0] = {half[WIDTH-1:1], 1'b0};

   for (genvar s = 0; s < STAGES; s++) begin : g_lvl
      localparam int DIST = 1 << s;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i >= DIST) begin : g_merge
            assign gk[s+1][i] = gk[s][i] | (pk[s][i] & gk[s][i-DIST]);
            assign pk[s+1][i] = pk[s][i] & pk[s][i-DIST];
         end else begin : g_pass
            assign gk[s+1][i] = gk[s][i];
            assign pk[s+1][i] = pk[s][i];
         end
      end
   end

   assign bin_o = half ^ {gk[STAGES][WIDTH-2:0], 1'b1};
   assign unused_prefix = gk[STAGES][WIDTH-1] ^ (^pk[STAGES]);

endmodule

// File: rtl/sd_product_tree.sv
module sd_product_tree #(
   parameter int WIDTH    = 48,
   parameter int NUM_PP   = 8,
   parameter int TREE_REG = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid_i,
   input  logic [NUM_PP*WIDTH-1:0] pp_pos_i,
   input  logic [NUM_PP*WIDTH-1:0] pp_neg_i,
   output logic                    out_valid_o,
   output logic [WIDTH-1:0]        product_o
);

   localparam int LAT = 1 + TREE_REG;

   if (NUM_PP < 2 || (NUM_PP & (NUM_PP - 1)) != 0) begin : g_bad_ops
      $error("NUM_PP must be a power of two and at least 2");
   end
   if (TREE_REG != 0 && TREE_REG != 1) begin : g_bad_reg
      $error("TREE_REG must be 0 or 1");
   end
   if (WIDTH < 4) begin : g_bad_width
      $error("WIDTH must be at least 4");
   end

   logic [WIDTH-1:0] root_p, root_n;
   logic [WIDTH-1:0] stg_p, stg_n;
   logic             stg_v;
   logic [WIDTH-1:0] bin;

   sd_tree #(.WIDTH(WIDTH), .NUM_OPS(NUM_PP)) u_tree (
      .leaf_pos_i (pp_pos_i),
      .leaf_neg_i (pp_neg_i),
      .root_pos_o (root_p),
      .root_neg_o (root_n)
   );

   if (TREE_REG != 0) begin : g_treg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_v <= 1'b0;
            stg_p <= '0;
            stg_n <= '0;
         end else begin
            stg_v <= in_valid_i;
            stg_p <= root_p;
            stg_n <= root_n;
         end
      end
   end else begin : g_tcomb
      assign stg_v = in_valid_i;
      assign stg_p = root_p;
      assign stg_n = root_n;
   end

   sd_to_bin #(.WIDTH(WIDTH)) u_conv (
      .pos_i (stg_p),
      .neg_i (stg_n),
      .bin_o (bin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         product_o   <= '0;
      end else begin
         out_valid_o <= stg_v;
         if (stg_v) product_o <= bin;
      end
   end

   // ---------------- checks ----------------
   logic [WIDTH-1:0] leaf_sum;
   always_comb begin
      leaf_sum = '0;
      for (int k = 0; k < NUM_PP; k++) begin
         leaf_sum = leaf_sum + pp_pos_i[k*WIDTH +: WIDTH] - pp_neg_i[k*WIDTH +: WIDTH];
      end
   end

   // R1
   tree_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |-> ((root_p - root_n) == leaf_sum));

   // R2
   canon_dig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid_i |-> ((root_p & root_n) == '0));

   // R1
   conv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (product_o == $past(stg_p - stg_n)));

   // R5
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o == ($past(in_valid_i, LAT) && $past(rst_n, LAT)));

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid_o |-> $stable(product_o));

endmodule

// File: tb/sim_sd_product_tree.sv
module sim_sd_product_tree;

   localparam int W          = 48;
   localparam int N          = 8;
   localparam int OPW        = 24;
   localparam int TREE_REG   = 1;
   localparam int LAT        = 1 + TREE_REG;
   localparam int CLK_PERIOD = 10;
   localparam int NS         = 24;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [N*W-1:0] pp_pos = '0;
   logic [N*W-1:0] pp_neg = '0;
   logic           out_valid;
   logic [W-1:0]   product;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sd_product_tree #(.WIDTH(W), .NUM_PP(N), .TREE_REG(TREE_REG)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (in_valid),
      .pp_pos_i    (pp_pos),
      .pp_neg_i    (pp_neg),
      .out_valid_o (out_valid),
      .product_o   (product)
   );

   function automatic logic [W-1:0] ref_sum(input logic [N*W-1:0] p, input logic [N*W-1:0] n);
      logic [W-1:0] acc = '0;
      for (int k = 0; k < N; k++) acc = acc + p[k*W +: W] - n[k*W +: W];
      return acc;
   endfunction

   function automatic logic [W-1:0] ref_mul(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
      logic [W-1:0] ax, bx;
      ax = {{(W-OPW){a[OPW-1]}}, a};
      bx = {{(W-OPW){b[OPW-1]}}, b};
      return ax * bx;
   endfunction

   // radix-8 recoding; alt selects 2a-a for the single multiple
   task automatic booth_pp(input logic [OPW-1:0] a, input logic [OPW-1:0] b, input bit alt,
                           output logic [N*W-1:0] p, output logic [N*W-1:0] n);
      logic [W-1:0] ax, m1, m2, m4, pv, nv, tmp;
      logic lowb;
      int d, mag, s;
      ax = {{(W-OPW){a[OPW-1]}}, a};
      p = '0;
      n = '0;
      for (int k = 0; k < N; k++) begin
         s    = 3 * k;
         m1   = ax << s;
         m2   = ax << (s + 1);
         m4   = ax << (s + 2);
         lowb = (k == 0) ? 1'b0 : b[s-1];
         d    = int'(b[s]) + int'(lowb) + 2 * int'(b[s+1]) - 4 * int'(b[s+2]);
         mag  = (d < 0) ? -d : d;
         pv   = '0;
         nv   = '0;
         case (mag)
            1: begin if (alt) begin pv = m2; nv = m1; end else pv = m1; end
            2: pv = m2;
            3: begin pv = m4; nv = m1; end
            4: pv = m4;
            default: ;
         endcase
         if (d < 0) begin tmp = pv; pv = nv; nv = tmp; end
         p[k*W +: W] = pv;
         n[k*W +: W] = nv;
      end
   endtask

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_one(input logic [N*W-1:0] p, input logic [N*W-1:0] n,
                           input logic [W-1:0] exp, input string req);
      @(negedge clk);
      pp_pos   = p;
      pp_neg   = n;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (LAT > 1) chk(out_valid == 1'b0, "R5 valid early", W'(out_valid), '0);
      repeat (LAT - 1) @(negedge clk);
      chk(out_valid == 1'b1, "R5 valid at latency", W'(out_valid), W'(1));
      chk(product == exp, req, product, exp);
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 single pulse", W'(out_valid), '0);
   endtask

   logic [OPW-1:0] da [10];
   logic [OPW-1:0] db [10];
   logic [N*W-1:0] sp [NS];
   logic [N*W-1:0] sn [NS];
   logic [W-1:0]   se [NS];

   initial begin
      logic [N*W-1:0] p, n, p2, n2;
      logic [OPW-1:0] a, b;
      logic [W-1:0]   held;
      int unsigned    seed_v;
      seed_v = $urandom(32'd4242);

      repeat (3) @(negedge clk);
      // R7 reset state
      chk(out_valid == 1'b0, "R7 reset valid", W'(out_valid), '0);
      chk(product == '0, "R7 reset product", product, '0);
      rst_n = 1'b1;

      // R1 directed signed products
      da[0] = 24'd0;       db[0] = 24'd0;
      da[1] = 24'd1;       db[1] = 24'd1;
      da[2] = 24'hFFFFFF;  db[2] = 24'd1;
      da[3] = 24'hFFFFFF;  db[3] = 24'hFFFFFF;
      da[4] = 24'h7FFFFF;  db[4] = 24'h7FFFFF;
      da[5] = 24'h800000;  db[5] = 24'h800000;
      da[6] = 24'h800000;  db[6] = 24'h7FFFFF;
      da[7] = 24'h7FFFFF;  db[7] = 24'h800000;
      da[8] = 24'd12345;   db[8] = -24'sd678;
      da[9] = 24'h800000;  db[9] = 24'hFFFFFF;
      for (int i = 0; i < 10; i++) begin
         booth_pp(da[i], db[i], 1'b0, p, n);
         send_one(p, n, ref_mul(da[i], db[i]), "R1 directed product");
      end
      // R1: min*min = 2^46
      booth_pp(24'h800000, 24'h800000, 1'b0, p, n);
      send_one(p, n, 48'h4000_0000_0000, "R1 min times min");

      // R3 alternative encodings of the same partial products
      for (int i = 0; i < 10; i++) begin
         booth_pp(da[i], db[i], 1'b1, p2, n2);
         send_one(p2, n2, ref_mul(da[i], db[i]), "R3 alt encoding");
      end

      // R2 raw random digit pairs, both-set pairs included
      for (int i = 0; i < 30; i++) begin
         for (int k = 0; k < N; k++) begin
            p[k*W +: W] = {$urandom, $urandom} >> 16;
            n[k*W +: W] = {$urandom, $urandom} >> 16;
         end
         send_one(p, n, ref_sum(p, n), "R2 random digit pairs");
      end
      send_one({(N*W){1'b1}}, {(N*W){1'b1}}, '0, "R2 all pairs both set");

      // R4 wrap-around
      send_one({(N*W){1'b1}}, '0, 48'hFFFF_FFFF_FFF8, "R4 all plus ones");
      send_one('0, {(N*W){1'b1}}, 48'd8, "R4 all minus ones");
      send_one({N{1'b0, {(W-1){1'b1}}}}, '0, 48'hFFFF_FFFF_FFF8, "R4 max positive wrap");

      // R5 / R1 back-to-back stream
      for (int j = 0; j < NS; j++) begin
         a = OPW'($urandom);
         b = OPW'($urandom);
         booth_pp(a, b, j[0], sp[j], sn[j]);
         se[j] = ref_mul(a, b);
      end
      for (int j = 0; j < NS + LAT; j++) begin
         @(negedge clk);
         if (j >= LAT) begin
            chk(out_valid == 1'b1, "R5 stream valid", W'(out_valid), W'(1));
            chk(product == se[j-LAT], "R1 stream product", product, se[j-LAT]);
         end
         if (j < NS) begin
            pp_pos   = sp[j];
            pp_neg   = sn[j];
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end

      // R6 inputs without valid leave the result alone
      held = se[NS-1];
      for (int j = 0; j < 6; j++) begin
         @(negedge clk);
         pp_pos = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
         pp_neg = '0;
      end
      repeat (LAT + 1) @(negedge clk);
      chk(out_valid == 1'b0, "R6 no valid", W'(out_valid), '0);
      chk(product == held, "R6 product held", product, held);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R5 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule